// File: doc/BRIEF.md
# Memory Chip-Enable Gating Controller

This block sits between a host's active-low chip-enable line and an external static memory. While the system is healthy it forwards the enable to the memory unchanged, one register stage later. When the supervisor's reset-asserted flag rises, it write-protects the memory by forcing the conditioned enable high, so that a collapsing supply cannot corrupt stored data.

An access that is already running when reset arrives is not cut in half. The conditioned enable may stay low until the host releases its enable, or until a grace window of `GRACE_CYC` clock cycles has elapsed, whichever comes first. The window is counted from the first clock edge that samples reset high. After the window closes or the access ends, the output stays high for as long as reset lasts, and later falling edges of the input enable do not reopen the window. With the default clock of 125 MHz, a `GRACE_CYC` of 1875 gives a window of 15 µs. A board that does not use gating ties the input enable low. The output then follows reset alone.

Top module: `cegate_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `ce_out_n` is 1.
- R2: At every clock edge that samples `sys_rst` = 0, `ce_out_n` takes the value of `ce_in_n` sampled at that edge, so the pass-through latency is one cycle.
- R3: `ce_out_n` is 0 only after an edge that sampled `ce_in_n` = 0. An edge that samples `ce_in_n` = 1 always makes `ce_out_n` 1.
- R4: If `ce_out_n` is 1 at the first edge that samples `sys_rst` = 1, `ce_out_n` stays 1 for the whole reset period.
- R5: If `ce_out_n` and `ce_in_n` are both 0 at the first edge that samples `sys_rst` = 1, `ce_out_n` stays 0. It rises after the first later edge that samples `ce_in_n` = 1.
- R6: Within one reset period, the edge that samples reset for the (`GRACE_CYC`+1)-th time, and every later edge, leaves `ce_out_n` at 1. The output is low for at most `GRACE_CYC` cycles after reset is first sampled.
- R7: Once `ce_out_n` is 1 during reset, a new falling edge of `ce_in_n` does not start another grace window.
- R8: After reset ends, the first edge that samples `sys_rst` = 0 makes `ce_out_n` follow `ce_in_n` again.
- R9: With `ce_in_n` tied to 0, `ce_out_n` is 0 outside reset. During reset it stays 0 for `GRACE_CYC` cycles and is then 1 until reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the block's own logic |
| ce_in_n | input | 1 | Active-low chip enable from the host |
| sys_rst | input | 1 | Supervisor reset-asserted flag, active high |
| ce_out_n | output | 1 | Conditioned active-low chip enable to the memory |

## Verification
The bench targets five corner cases:
- **Access active when reset arrives.** The cycle must survive. A design that blocked it at once would cut an in-flight write.
- **Enable falling on the same edge as reset.** That access must be refused. A design that granted it grace would let a new write through under a failing supply.
- **Grace expiry landing on exactly the (`GRACE_CYC`+1)-th reset edge.** An off-by-one counter shows up as one cycle too many or too few of low output.
- **New falling edge of the input during reset.** It must not restart the window. A design that reloaded the timer there would reopen the memory.
- **Tied-low input.** It runs the full window on every reset and resumes on release. A design that waited for a fresh falling edge would stay blocked forever.

// File: rtl/cegate_pkg.sv
package cegate_pkg;

    // Operating phase of the gate
    typedef enum logic [1:0] {
        GS_PASS  = 2'd0,   // reset idle: output follows the input
        GS_GRACE = 2'd1,   // reset active, in-flight access allowed to finish
        GS_BLOCK = 2'd2    // reset active, output forced inactive
    } gate_st_e;

    typedef struct packed {
        gate_st_e st;
        logic     ce_n;
    } gate_reg_t;

endpackage

// File: rtl/cegate_grace_tmr.sv
module cegate_grace_tmr #(
    parameter int GRACE_CYC = 1875
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(GRACE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(GRACE_CYC);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (load_i) begin
            cnt_d = ONE;
        end else if (run_i) begin
            cnt_d = (cnt_q >= LIMIT) ? LIMIT : cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q >= LIMIT);

endmodule

// File: rtl/cegate_fsm.sv
module cegate_fsm
    import cegate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_in_n,
    input  logic sys_rst,
    input  logic expired_i,
    output logic tmr_load_o,
    output logic tmr_run_o,
    output logic ce_out_n
);
    gate_reg_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        tmr_load_o = 1'b0;
        tmr_run_o  = 1'b0;
        if (!sys_rst) begin
            r_d.st   = GS_PASS;
            r_d.ce_n = ce_in_n;
        end else begin
            unique case (r_q.st)
                GS_PASS: begin
                    if (!r_q.ce_n && !ce_in_n) begin
                        r_d.st     = GS_GRACE;
                        r_d.ce_n   = 1'b0;
                        tmr_load_o = 1'b1;
                    end else begin
                        r_d.st   = GS_BLOCK;
                        r_d.ce_n = 1'b1;
                    end
                end
                GS_GRACE: begin
                    if (ce_in_n || expired_i) begin
                        r_d.st   = GS_BLOCK;
                        r_d.ce_n = 1'b1;
                    end else begin
                        r_d.ce_n  = 1'b0;
                        tmr_run_o = 1'b1;
                    end
                end
                default: begin
                    r_d.st   = GS_BLOCK;
                    r_d.ce_n = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= GS_PASS;
            r_q.ce_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ce_out_n = r_q.ce_n;

endmodule

// File: rtl/cegate_ctrl.sv
module cegate_ctrl #(
    parameter int GRACE_CYC = 1875
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_in_n,
    input  logic sys_rst,
    output logic ce_out_n
);
    logic tmr_load, tmr_run, tmr_expired;

    cegate_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_in_n    (ce_in_n),
        .sys_rst    (sys_rst),
        .expired_i  (tmr_expired),
        .tmr_load_o (tmr_load),
        .tmr_run_o  (tmr_run),
        .ce_out_n   (ce_out_n)
    );

    cegate_grace_tmr #(.GRACE_CYC(GRACE_CYC)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .run_i     (tmr_run),
        .expired_o (tmr_expired)
    );

endmodule

// File: rtl/cegate_ctrl_chk.sv
module cegate_ctrl_chk #(
    parameter int GRACE_CYC = 1875
) (
    input logic clk,
    input logic rst_n,
    input logic ce_in_n,
    input logic sys_rst,
    input logic ce_out_n
);
    localparam int RW = $clog2(GRACE_CYC + 2);
    localparam logic [RW-1:0] RLIM = RW'(GRACE_CYC);

    // Edges that have sampled reset high in the current reset period
    logic [RW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            run_q <= '0;
        else if (!sys_rst)     run_q <= '0;
        else if (run_q < RLIM) run_q <= run_q + RW'(1);
    end

    AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst |=> (ce_out_n == $past(ce_in_n)));                  // R2

    AST_LOW_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        ce_in_n |=> ce_out_n);                                       // R3

    AST_IDLE_STAYS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && ce_out_n) |=> ce_out_n);                         // R4

    AST_GRACE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && !ce_in_n && !ce_out_n && run_q < RLIM) |=> !ce_out_n); // R5

    AST_GRACE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && run_q >= RLIM) |=> ce_out_n);                    // R6

endmodule

bind cegate_ctrl cegate_ctrl_chk #(.GRACE_CYC(GRACE_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_in_n  (ce_in_n),
    .sys_rst  (sys_rst),
    .ce_out_n (ce_out_n)
);

// File: tb/sim_cegate_ctrl.sv
module sim_cegate_ctrl;
    localparam int N = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_in_n = 1'b1;
    logic sys_rst = 1'b0;
    logic ce_out_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    cegate_ctrl #(.GRACE_CYC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n),
        .sys_rst(sys_rst), .ce_out_n(ce_out_n)
    );

    // Reference model from the requirements: 0 free, 1 grace, 2 blocked
    int    m_mode = 0;
    int    m_cnt  = 0;
    logic  m_exp  = 1'b1;
    string m_tag  = "R1";

    function automatic void model_edge(input logic ce, input logic sr);
        if (!sr) begin
            m_mode = 0; m_cnt = 0; m_exp = ce; m_tag = "R2";
        end else if (m_mode == 0) begin
            if (!m_exp && !ce) begin
                m_mode = 1; m_cnt = 1; m_exp = 1'b0; m_tag = "R5";
            end else begin
                m_mode = 2; m_exp = 1'b1; m_tag = "R4";
            end
        end else if (m_mode == 1) begin
            if (ce) begin
                m_mode = 2; m_exp = 1'b1; m_tag = "R5";
            end else if (m_cnt >= N) begin
                m_mode = 2; m_exp = 1'b1; m_tag = "R6";
            end else begin
                m_cnt++; m_exp = 1'b0; m_tag = "R6";
            end
        end else begin
            m_exp = 1'b1; m_tag = "R7";
        end
    endfunction

    task automatic chk(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: ce_out_n=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input logic ce, input logic sr, input string tag);
        ce_in_n = ce;
        sys_rst = sr;
        @(posedge clk);
        model_edge(ce, sr);
        @(negedge clk);
        chk(ce_out_n, m_exp, (tag == "") ? m_tag : tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0C0E));

        // R1: reset state
        repeat (3) @(negedge clk);
        ce_in_n = 1'b0;
        @(negedge clk);
        chk(ce_out_n, 1'b1, "R1");
        rst_n = 1'b1;
        ce_in_n = 1'b1;
        @(negedge clk);
        chk(ce_out_n, 1'b1, "R1");

        // R2 / R3: pass-through patterns
        step(0, 0, "R2"); step(1, 0, "R3"); step(0, 0, "R2");
        step(0, 0, "R2"); step(1, 0, "R3"); step(1, 0, "R2");

        // R5: grace ended by input release, then R7 new falling edge, R8 release
        step(0, 0, "R2");
        step(0, 1, "R5"); step(0, 1, "R5"); step(1, 1, "R5");
        step(0, 1, "R7"); step(0, 1, "R7"); step(1, 1, "R7");
        step(0, 0, "R8"); step(1, 0, "R8");

        // R6: grace expiry on the (N+1)-th reset edge
        step(0, 0, "R2");
        for (int k = 0; k <= N; k++) step(0, 1, "R6");
        step(0, 1, "R6"); step(1, 1, "R7"); step(0, 1, "R7");
        step(0, 0, "R8");

        // R4: reset while idle, and enable falling on the same edge as reset
        step(1, 0, "R2");
        step(0, 1, "R4");
        for (int k = 0; k < N + 3; k++) step(k[0], 1, "R4");
        step(1, 0, "R8");

        // R9: input tied low through a whole reset period
        step(0, 0, "R9");
        for (int k = 0; k < N + 4; k++) step(0, 1, "R9");
        step(0, 0, "R9"); step(0, 0, "R9");

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic ce, sr;
            ce = ce_in_n;
            sr = sys_rst;
            if ($urandom_range(3, 0) == 0)  ce = ~ce;
            if ($urandom_range(24, 0) == 0) sr = ~sr;
            step(ce, sr, "");
        end

        finish_run();
    end
endmodule